// File: doc/BRIEF.md
# Dual-Group Masked Interrupt Register Bank

This block holds interrupt state for a peripheral that reports two classes of events: ordinary events and error events. Each class owns a sticky status register, a mask register, and two strobe registers. One strobe unmasks bits and the other masks them. Hardware event sources pulse per-bit set inputs, and software sees the result through a 32-bit word register port.

Software clears pending status by writing ones to the status register. The mask can only be changed through the unmask and mask strobe registers, so a read-modify-write race on the mask cannot occur. A single registered level interrupt output reports whether either group has a bit that is both pending and unmasked.

Top module: `irqb_top`

## Requirements
- R1: After reset both status registers read 0, the normal mask reads 0x07FFFFFF, the error mask reads 0xFFFFFFFF, and the interrupt output is low.
- R2: Registers are selected by byte address with bits [1:0] ignored. The normal group uses 0x04 (status), 0x08 (mask), 0x0C (unmask strobe) and 0x10 (mask strobe). The error group uses 0x14, 0x18, 0x1C and 0x20 for the same four registers. Any other address reads 0, and a write to it changes nothing.
- R3: A one on a bit of an event input sets the matching status bit at the next clock edge. The bit stays set until software clears it.
- R4: Writing to a status register clears every status bit whose written bit is one and leaves the other bits unchanged.
- R5: When an event pulse and a software clear hit the same status bit in the same cycle, the bit ends up set.
- R6: Writing to an unmask strobe register clears the mask bits that are one in the written value.
- R7: Writing to a mask strobe register sets the mask bits that are one in the written value.
- R8: Writes to either mask register address leave the mask unchanged.
- R9: Both strobe registers read back as 0.
- R10: The interrupt output is high exactly one cycle after the cycle in which (status AND NOT mask) is nonzero in either group. It therefore lags each status or mask change by one clock.
- R11: A write or event aimed at one group leaves the other group's status and mask unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | ADDR_W | Byte address of the register access |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for reg_addr (combinational) |
| norm_evt | input | DATA_W | Per-bit set pulses, normal group |
| err_evt | input | DATA_W | Per-bit set pulses, error group |
| irq_o | output | 1 | Registered level interrupt |

## Verification
The hardest case to reach from the ports is a cycle in which an event pulse and a software clear land on the same status bit. The design must keep the bit set. The stimulus table drives a status-clear write and an event pulse on the same bit within one vector, then reads the status back.

The one-cycle lag of the interrupt output is also hard to observe. A directed test samples the output after the first and after the second edge following an unmasked event. Unmapped addresses, an address with nonzero low bits, and simultaneous traffic to both groups are also in the table.

// File: rtl/irqb_pkg.sv
package irqb_pkg;
   // number of register groups (normal, error)
   localparam int unsigned NUM_GRP       = 2;
   // first word index of group 0 and words per group
   localparam int unsigned FIRST_WORD    = 1;
   localparam int unsigned WORDS_PER_GRP = 4;

   // order within a group is fixed by the address map
   typedef enum logic [1:0] {
      K_STS = 2'd0,
      K_MSK = 2'd1,
      K_UNM = 2'd2,
      K_MSS = 2'd3
   } reg_kind_e;
endpackage

// File: rtl/irqb_decode.sv
module irqb_decode
   import irqb_pkg::*;
#(
   parameter int unsigned ADDR_W = 8
) (
   input  logic [ADDR_W-1:0]  addr_i,
   input  logic               wr_i,
   output logic [NUM_GRP-1:0] sts_wr_o,
   output logic [NUM_GRP-1:0] unm_wr_o,
   output logic [NUM_GRP-1:0] mss_wr_o,
   output logic               hit_o,
   output logic [ADDR_W-1:0]  grp_o,
   output reg_kind_e          kind_o
);
   localparam logic [ADDR_W-1:0] LAST_WORD = ADDR_W'(FIRST_WORD + NUM_GRP*WORDS_PER_GRP - 1);

   logic [ADDR_W-1:0] word;
   logic [ADDR_W-1:0] wsub;

   assign word   = addr_i >> 2;
   assign wsub   = word - ADDR_W'(FIRST_WORD);
   assign grp_o  = wsub >> 2;
   assign kind_o = reg_kind_e'(wsub[1:0]);
   assign hit_o  = (word >= ADDR_W'(FIRST_WORD)) && (word <= LAST_WORD);

   for (genvar g = 0; g < NUM_GRP; g++) begin : g_strobe
      logic sel;
      assign sel         = wr_i && hit_o && (grp_o == ADDR_W'(g));
      assign sts_wr_o[g] = sel && (kind_o == K_STS);
      assign unm_wr_o[g] = sel && (kind_o == K_UNM);
      assign mss_wr_o[g] = sel && (kind_o == K_MSS);
   end

   // R11: one write never reaches two groups
   always_comb begin
      assert_one_group_R11: assert ($onehot0(sts_wr_o | unm_wr_o | mss_wr_o));
   end
endmodule

// File: rtl/irqb_group.sv
module irqb_group #(
   parameter int unsigned     DATA_W   = 32,
   parameter logic [DATA_W-1:0] MASK_RST = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] set_i,
   input  logic              clr_i,
   input  logic              unm_i,
   input  logic              mss_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [DATA_W-1:0] status_o,
   output logic [DATA_W-1:0] mask_o,
   output logic              pend_o
);
   logic [DATA_W-1:0] status_q;
   logic [DATA_W-1:0] mask_q;
   logic [DATA_W-1:0] clr_bits;

   assign clr_bits = clr_i ? wdata_i : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         status_q <= '0;
         mask_q   <= MASK_RST;
      end else begin
         // set applied after clear: event beats software clear
         status_q <= (status_q & ~clr_bits) | set_i;
         if (unm_i)
            mask_q <= mask_q & ~wdata_i;
         else if (mss_i)
            mask_q <= mask_q | wdata_i;
      end
   end

   assign status_o = status_q;
   assign mask_o   = mask_q;
   assign pend_o   = |(status_q & ~mask_q);

   assert_set_sticks_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (set_i != '0) |=> ((status_q & $past(set_i)) == $past(set_i)));

   assert_w1c_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && set_i == '0) |=> ((status_q & $past(wdata_i)) == '0));

   assert_set_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && ((set_i & wdata_i) != '0)) |=>
         ((status_q & $past(set_i & wdata_i)) == $past(set_i & wdata_i)));

   assert_unmask_R6: assert property (@(posedge clk) disable iff (!rst_n)
      unm_i |=> ((mask_q & $past(wdata_i)) == '0));

   assert_mask_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
      mss_i |=> ((mask_q & $past(wdata_i)) == $past(wdata_i)));

   assert_mask_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!unm_i && !mss_i) |=> $stable(mask_q));
endmodule

// File: rtl/irqb_irq.sv
module irqb_irq #(
   parameter int unsigned NUM_SRC = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] pend_i,
   output logic               irq_o
);
   logic irq_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_q <= 1'b0;
      else        irq_q <= |pend_i;
   end

   assign irq_o = irq_q;

   assert_irq_rise_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_i != '0) |=> irq_q);

   assert_irq_fall_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_i == '0) |=> !irq_q);
endmodule

// File: rtl/irqb_top.sv
module irqb_top
   import irqb_pkg::*;
#(
   parameter int unsigned       DATA_W        = 32,
   parameter int unsigned       ADDR_W        = 8,
   parameter logic [DATA_W-1:0] NORM_MASK_RST = 32'h07FF_FFFF,
   parameter logic [DATA_W-1:0] ERR_MASK_RST  = 32'hFFFF_FFFF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic [DATA_W-1:0] norm_evt,
   input  logic [DATA_W-1:0] err_evt,
   output logic              irq_o
);
   if (DATA_W < 1 || DATA_W > 32) begin : g_bad_data_w
      $error("irqb_top: DATA_W must be 1..32");
   end
   if (ADDR_W < 6) begin : g_bad_addr_w
      $error("irqb_top: ADDR_W must cover the address map");
   end

   logic [NUM_GRP-1:0] sts_wr, unm_wr, mss_wr, pend;
   logic               hit;
   logic [ADDR_W-1:0]  grp;
   reg_kind_e          kind;
   logic [DATA_W-1:0]  evt_a    [NUM_GRP];
   logic [DATA_W-1:0]  status_a [NUM_GRP];
   logic [DATA_W-1:0]  mask_a   [NUM_GRP];

   assign evt_a[0] = norm_evt;
   assign evt_a[1] = err_evt;

   irqb_decode #(.ADDR_W(ADDR_W)) u_dec (
      .addr_i   (reg_addr),
      .wr_i     (reg_wr),
      .sts_wr_o (sts_wr),
      .unm_wr_o (unm_wr),
      .mss_wr_o (mss_wr),
      .hit_o    (hit),
      .grp_o    (grp),
      .kind_o   (kind)
   );

   for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
      localparam logic [DATA_W-1:0] RST_G = (g == 0) ? NORM_MASK_RST : ERR_MASK_RST;
      irqb_group #(.DATA_W(DATA_W), .MASK_RST(RST_G)) u_grp (
         .clk      (clk),
         .rst_n    (rst_n),
         .set_i    (evt_a[g]),
         .clr_i    (sts_wr[g]),
         .unm_i    (unm_wr[g]),
         .mss_i    (mss_wr[g]),
         .wdata_i  (reg_wdata),
         .status_o (status_a[g]),
         .mask_o   (mask_a[g]),
         .pend_o   (pend[g])
      );
   end

   irqb_irq #(.NUM_SRC(NUM_GRP)) u_irq (
      .clk    (clk),
      .rst_n  (rst_n),
      .pend_i (pend),
      .irq_o  (irq_o)
   );

   // read mux: strobe registers and unmapped words return zero
   always_comb begin
      reg_rdata = '0;
      for (int g = 0; g < NUM_GRP; g++) begin
         if (hit && grp == ADDR_W'(g)) begin
            unique case (kind)
               K_STS:   reg_rdata = status_a[g];
               K_MSK:   reg_rdata = mask_a[g];
               default: reg_rdata = '0;
            endcase
         end
      end
   end

   // R9: strobe registers read as zero
   always_comb begin
      if (hit && (kind == K_UNM || kind == K_MSS))
         assert_strobe_rd_zero_R9: assert (reg_rdata == '0);
   end

   // R2: a write outside the map changes no status
   assert_unmapped_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && !hit && norm_evt == '0 && err_evt == '0) |=>
         ($stable(status_a[0]) && $stable(status_a[1])));
endmodule

// File: tb/irqb_top_tb.sv
`timescale 1ns/1ps
module irqb_top_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [7:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic [31:0] norm_evt = '0;
   logic [31:0] err_evt = '0;
   logic        irq_o;

   int n_chk = 0;
   int n_fail = 0;

   always #2.5 clk = ~clk;

   irqb_top u_dut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .norm_evt(norm_evt),
      .err_evt(err_evt), .irq_o(irq_o)
   );

   typedef struct packed {
      logic        wr;
      logic [7:0]  addr;
      logic [31:0] wdata;
      logic [31:0] nset;
      logic [31:0] eset;
      logic [7:0]  chk;
      logic [31:0] exp;
      logic        irq;
      logic [7:0]  req;
   } vec_t;

   localparam int NV = 21;
   localparam vec_t VECS [NV] = '{
      '{1'b0, 8'h00, 32'h0,        32'h1,        32'h0, 8'h04, 32'h1,        1'b0, 8'd3 },  // R3 masked set
      '{1'b1, 8'h0C, 32'h1,        32'h0,        32'h0, 8'h08, 32'h07FFFFFE, 1'b1, 8'd6 },  // R6
      '{1'b0, 8'h00, 32'h0,        32'h0,        32'h0, 8'h0C, 32'h0,        1'b1, 8'd9 },  // R9
      '{1'b1, 8'h04, 32'h1,        32'h0,        32'h0, 8'h04, 32'h0,        1'b0, 8'd4 },  // R4
      '{1'b0, 8'h00, 32'h0,        32'h08000000, 32'h0, 8'h04, 32'h08000000, 1'b1, 8'd3 },  // R3
      '{1'b1, 8'h04, 32'h08000000, 32'h08000000, 32'h0, 8'h04, 32'h08000000, 1'b1, 8'd5 },  // R5
      '{1'b1, 8'h04, 32'hFFFFFFFF, 32'h0,        32'h0, 8'h04, 32'h0,        1'b0, 8'd4 },  // R4
      '{1'b1, 8'h08, 32'h0,        32'h0,        32'h0, 8'h08, 32'h07FFFFFE, 1'b0, 8'd8 },  // R8
      '{1'b0, 8'h00, 32'h0,        32'h0,        32'h2, 8'h14, 32'h2,        1'b0, 8'd3 },  // R3 error group
      '{1'b1, 8'h1C, 32'h2,        32'h0,        32'h0, 8'h18, 32'hFFFFFFFD, 1'b1, 8'd6 },  // R6
      '{1'b1, 8'h20, 32'h2,        32'h0,        32'h0, 8'h18, 32'hFFFFFFFF, 1'b0, 8'd7 },  // R7
      '{1'b1, 8'h18, 32'h0,        32'h0,        32'h0, 8'h18, 32'hFFFFFFFF, 1'b0, 8'd8 },  // R8
      '{1'b1, 8'h10, 32'h1,        32'h0,        32'h0, 8'h08, 32'h07FFFFFF, 1'b0, 8'd7 },  // R7
      '{1'b1, 8'h14, 32'hFFFFFFFF, 32'h08000000, 32'h0, 8'h04, 32'h08000000, 1'b1, 8'd11},  // R11
      '{1'b0, 8'h00, 32'h0,        32'h0,        32'h0, 8'h14, 32'h0,        1'b1, 8'd4 },  // R4
      '{1'b1, 8'h24, 32'hFFFFFFFF, 32'h0,        32'h0, 8'h24, 32'h0,        1'b1, 8'd2 },  // R2 unmapped
      '{1'b0, 8'h00, 32'h0,        32'h0,        32'h0, 8'h04, 32'h08000000, 1'b1, 8'd2 },  // R2 no effect
      '{1'b1, 8'h05, 32'h08000000, 32'h0,        32'h0, 8'h04, 32'h0,        1'b0, 8'd2 },  // R2 low bits
      '{1'b0, 8'h00, 32'h0,        32'h0,        32'h0, 8'h10, 32'h0,        1'b0, 8'd9 },  // R9
      '{1'b0, 8'h00, 32'h0,        32'h0,        32'h0, 8'h1C, 32'h0,        1'b0, 8'd9 },  // R9
      '{1'b0, 8'h00, 32'h0,        32'h0,        32'h0, 8'h00, 32'h0,        1'b0, 8'd2 }   // R2
   };

   task automatic check(input int req, input string what, input logic [31:0] act,
                        input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic read_chk(input int req, input logic [7:0] a, input logic [31:0] exp);
      reg_addr = a;
      #1;
      check(req, "rdata", reg_rdata, exp);
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   initial begin
      #(5.0 * 100000);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      // R1: reset values
      #1;
      read_chk(1, 8'h04, 32'h0);
      read_chk(1, 8'h08, 32'h07FFFFFF);
      read_chk(1, 8'h14, 32'h0);
      read_chk(1, 8'h18, 32'hFFFFFFFF);
      check(1, "irq", {31'b0, irq_o}, 32'h0);
      @(negedge clk);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         reg_wr    = VECS[i].wr;
         reg_addr  = VECS[i].addr;
         reg_wdata = VECS[i].wdata;
         norm_evt  = VECS[i].nset;
         err_evt   = VECS[i].eset;
         @(posedge clk);
         @(negedge clk);
         reg_wr   = 1'b0;
         norm_evt = '0;
         err_evt  = '0;
         read_chk(int'(VECS[i].req), VECS[i].chk, VECS[i].exp);
         @(posedge clk);
         @(negedge clk);
         #1;
         check(int'(VECS[i].req), "irq", {31'b0, irq_o}, {31'b0, VECS[i].irq});
      end

      // R10: interrupt lags the status change by one edge
      @(negedge clk);
      norm_evt = 32'h08000000;
      @(posedge clk);
      @(negedge clk);
      norm_evt = '0;
      #1;
      check(10, "irq first edge", {31'b0, irq_o}, 32'h0);
      @(posedge clk);
      @(negedge clk);
      #1;
      check(10, "irq second edge", {31'b0, irq_o}, 32'h1);

      // R10: masking the pending bit drops irq one edge later
      reg_wr = 1'b1; reg_addr = 8'h10; reg_wdata = 32'h08000000;
      @(posedge clk);
      @(negedge clk);
      reg_wr = 1'b0;
      #1;
      check(10, "irq still high", {31'b0, irq_o}, 32'h1);
      @(posedge clk);
      @(negedge clk);
      #1;
      check(10, "irq dropped", {31'b0, irq_o}, 32'h0);

      // R1: reset mid-run restores reset state
      rst_n = 1'b0;
      read_chk(1, 8'h04, 32'h0);
      read_chk(1, 8'h08, 32'h07FFFFFF);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      finish_run();
   end
endmodule